// File: doc/BRIEF.md
# USB OUT Endpoint Receive Packet Buffer

This block is the receive store of one USB OUT endpoint. A serial interface engine streams packet bytes in and then marks the packet end with a good-or-bad flag. The buffer keeps the bytes of packets that end cleanly in a circular byte memory. A CPU then sees each stored packet through four byte-wide registers: a maximum-packet-size setting, a byte count split over two registers, and a data port that pops one byte per read.

Software writes the maximum packet size. The buffer compares the resulting effective size with half the memory depth and picks one of two modes. In the first mode it holds one packet at a time. In the second it holds two packets, so the engine can fill one while the CPU drains the other.

The byte stream uses valid/ready. A byte moves on a clock edge where `sie_valid` and `sie_ready` are both high. `sie_ready` falls when every packet slot the current mode allows holds an unread packet. The engine must then hold off. Any byte or end strobe offered while `sie_ready` is low is dropped. A byte offered in the same cycle as `sie_end` counts as part of the packet that ends there. A setting changed while packets are held applies at once, so software changes it only while the buffer is empty.

Top module: `usb_rx_pktbuf`

## Requirements
- R1: Register 0 is an 8-bit read/write packet-size setting. It resets to 1 when SCALED=1 and to 8 otherwise. The effective size is the setting times 8 when SCALED=1 and the setting itself otherwise. The limit used for packets is the effective size or the memory depth, whichever is smaller.
- R2: When the effective size is at most half the memory depth, two packets can be held. Otherwise one packet can be held.
- R3: `sie_ready` is low exactly when the number of held, unread packets equals the number the mode allows. Bytes and end strobes offered while it is low are dropped and change no stored state.
- R4: A packet that ends with `sie_good` high and has 1 up to the limit bytes is stored. Reads of register 3 then return its bytes in arrival order.
- R5: A packet that ends with `sie_good` low is discarded, and the presented count does not change.
- R6: A packet with more bytes than the limit is discarded, even if it ends good.
- R7: Register 1 returns count bits 7:0. Register 2 returns count bits 9:8 in its bits 1:0, and its bits 7:2 read 0. Both registers reset to 0, and writes to them are ignored.
- R8: A read of register 1 latches count bits 9:8. A later read of register 2 returns those latched bits, even if the count has changed in between.
- R9: The count shows the oldest unread packet, or 0 when the buffer is empty. After the last byte of that packet is read, the next packet's count is shown. A register 3 read while the buffer is empty returns 0 and has no effect.
- R10: A packet that ends good with zero bytes is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_valid | input | 1 | Byte valid from the engine |
| sie_data | input | 8 | Packet byte |
| sie_ready | output | 1 | High while a packet slot is free |
| sie_end | input | 1 | Packet end strobe |
| sie_good | input | 1 | Packet received without error, sampled with sie_end |
| cpu_addr | input | 2 | Register select: 0 size, 1 count low, 2 count high, 3 data |
| cpu_rd | input | 1 | Read strobe; side effects at the clock edge |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data, 0 when cpu_rd is low |

## Verification
A table of packets varies the size setting, the length, the end flag and the byte pattern:
- a packet of exactly the limit is stored, while one byte more is dropped;
- a bad ending is told apart from a good one;
- a zero-length packet is told apart from a short one;
- a 256-byte packet exercises the high count bits.

Directed sequences cover the rest:
- Two packets at a size of exactly half the depth show that two slots exist and that counts advance oldest first.
- A size one step above half the depth shows that only one slot exists.
- Bytes pushed into a full buffer must not appear later.
- A low-register read made before a large packet lands must keep the earlier high bits for the next high-register read.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int CNT_W = 10;
  localparam int LIM_W = 11;

  typedef enum logic [1:0] {
    REG_MAXP   = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_DATA   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pktbuf_cfg.sv
module pktbuf_cfg
  import usb_rx_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter bit SCALED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_maxp,
  input  logic [7:0]       wdata,
  output logic [7:0]       maxp_q,
  output logic [LIM_W-1:0] limit,
  output logic             dual
);
  localparam logic [7:0]       RST_VAL = SCALED ? 8'd1 : 8'd8;
  localparam logic [LIM_W-1:0] DEPTH_L = LIM_W'(DEPTH);
  localparam logic [LIM_W-1:0] HALF_L  = LIM_W'(DEPTH / 2);

  logic [LIM_W-1:0] eff;

  always_ff @(posedge clk) begin
    if (!rst_n)       maxp_q <= RST_VAL;
    else if (wr_maxp) maxp_q <= wdata;
  end

  generate
    if (SCALED) begin : g_scaled
      assign eff = {maxp_q, 3'b000};
    end else begin : g_plain
      assign eff = {3'b000, maxp_q};
    end
  endgenerate

  assign limit = (eff > DEPTH_L) ? DEPTH_L : eff;
  assign dual  = (eff <= HALF_L);
endmodule

// File: rtl/pktbuf_store.sv
module pktbuf_store
  import usb_rx_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             pkt_end,
  input  logic             pkt_good,
  input  logic [LIM_W-1:0] limit,
  input  logic             dual,
  input  logic             pop_byte,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] head_cnt
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wtmp, wbase, rptr;
  logic [LIM_W-1:0] wcnt;
  logic             ovf;
  logic [CNT_W-1:0] ridx;
  logic [CNT_W-1:0] cq [2];
  logic             cq_head, cq_tail;
  logic [1:0]       used;

  logic             byte_acc, do_write, ovf_next, end_acc, commit, pop, has_pkt;
  logic [LIM_W-1:0] wcnt_next;
  logic [AW-1:0]    wtmp_next;

  assign in_ready  = used < (dual ? 2'd2 : 2'd1);
  assign has_pkt   = (used != 2'd0);
  assign byte_acc  = in_valid && in_ready;
  assign do_write  = byte_acc && (wcnt < limit);
  assign ovf_next  = ovf || (byte_acc && !(wcnt < limit));
  assign wcnt_next = wcnt + LIM_W'(do_write);
  assign wtmp_next = wtmp + AW'(do_write);
  assign end_acc   = pkt_end && in_ready;
  assign commit    = end_acc && pkt_good && !ovf_next && (wcnt_next != '0);
  assign pop       = pop_byte && has_pkt && ((ridx + 1'b1) == head_cnt);

  assign rd_byte  = has_pkt ? mem[rptr] : 8'h00;
  assign head_cnt = has_pkt ? cq[cq_head] : '0;

  always_ff @(posedge clk) begin
    if (do_write) mem[wtmp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wtmp    <= '0;
      wbase   <= '0;
      wcnt    <= '0;
      ovf     <= 1'b0;
      cq[0]   <= '0;
      cq[1]   <= '0;
      cq_tail <= 1'b0;
    end else if (end_acc) begin
      wcnt <= '0;
      ovf  <= 1'b0;
      if (commit) begin
        wtmp        <= wtmp_next;
        wbase       <= wtmp_next;
        cq[cq_tail] <= wcnt_next[CNT_W-1:0];
        cq_tail     <= ~cq_tail;
      end else begin
        wtmp <= wbase;
      end
    end else begin
      wcnt <= wcnt_next;
      ovf  <= ovf_next;
      wtmp <= wtmp_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr    <= '0;
      ridx    <= '0;
      cq_head <= 1'b0;
      used    <= 2'd0;
    end else begin
      if (pop_byte && has_pkt) begin
        rptr <= rptr + 1'b1;
        ridx <= pop ? '0 : ridx + 1'b1;
      end
      if (pop) cq_head <= ~cq_head;
      used <= used + {1'b0, commit} - {1'b0, pop};
    end
  end

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(wcnt)); // R3
  AST_BAD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !pkt_good) |=> (used <= $past(used))); // R5
  AST_OVF_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && in_ready && in_valid && (wcnt >= limit)) |=> (used <= $past(used))); // R6
  AST_SLOTS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= 2'd2); // R2
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_byte && !has_pkt) |=> $stable(rptr)); // R9
endmodule

// File: rtl/pktbuf_regs.sv
module pktbuf_regs
  import usb_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [7:0]       maxp_q,
  input  logic [CNT_W-1:0] head_cnt,
  input  logic [7:0]       rd_byte,
  output logic [7:0]       rdata,
  output logic             wr_maxp,
  output logic             pop_byte
);
  logic [1:0] shadow;
  logic       rd_lo;

  assign rd_lo    = rd_en && (addr == REG_CNT_LO);
  assign wr_maxp  = wr_en && (addr == REG_MAXP);
  assign pop_byte = rd_en && (addr == REG_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n)     shadow <= 2'b00;
    else if (rd_lo) shadow <= head_cnt[9:8];
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      unique case (addr)
        REG_MAXP:   rdata = maxp_q;
        REG_CNT_LO: rdata = head_cnt[7:0];
        REG_CNT_HI: rdata = {6'b000000, shadow};
        default:    rdata = rd_byte;
      endcase
    end
  end

  AST_HI_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == REG_CNT_HI) |-> (rdata[7:2] == 6'd0)); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(shadow)); // R8
endmodule

// File: rtl/usb_rx_pktbuf.sv
module usb_rx_pktbuf
  import usb_rx_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter bit SCALED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sie_valid,
  input  logic [7:0] sie_data,
  output logic       sie_ready,
  input  logic       sie_end,
  input  logic       sie_good,
  input  logic [1:0] cpu_addr,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata
);
  logic [7:0]       maxp_q, rd_byte;
  logic [LIM_W-1:0] limit;
  logic             dual, wr_maxp, pop_byte;
  logic [CNT_W-1:0] head_cnt;

  pktbuf_cfg #(.DEPTH(DEPTH), .SCALED(SCALED)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_maxp(wr_maxp), .wdata(cpu_wdata),
    .maxp_q(maxp_q), .limit(limit), .dual(dual)
  );

  pktbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .in_valid(sie_valid), .in_data(sie_data),
    .in_ready(sie_ready), .pkt_end(sie_end), .pkt_good(sie_good),
    .limit(limit), .dual(dual), .pop_byte(pop_byte), .rd_byte(rd_byte),
    .head_cnt(head_cnt)
  );

  pktbuf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd_en(cpu_rd), .wr_en(cpu_wr),
    .maxp_q(maxp_q), .head_cnt(head_cnt), .rd_byte(rd_byte),
    .rdata(cpu_rdata), .wr_maxp(wr_maxp), .pop_byte(pop_byte)
  );
endmodule

// File: tb/usb_rx_pktbuf_test.sv
`timescale 1ns/1ps
module usb_rx_pktbuf_test;
  localparam int DEPTH = 256;
  localparam int NV = 8;
  // fields: [31:24] size setting, [23:12] length, [11] good flag, [7:0] seed
  localparam logic [31:0] VEC [NV] = '{
    {8'd1,  12'd8,   1'b1, 3'b0, 8'h10},
    {8'd1,  12'd9,   1'b1, 3'b0, 8'h20},
    {8'd4,  12'd5,   1'b0, 3'b0, 8'h30},
    {8'd4,  12'd32,  1'b1, 3'b0, 8'h40},
    {8'd4,  12'd0,   1'b1, 3'b0, 8'h00},
    {8'd32, 12'd256, 1'b1, 3'b0, 8'h50},
    {8'd2,  12'd1,   1'b1, 3'b0, 8'h60},
    {8'd20, 12'd160, 1'b1, 3'b0, 8'h70}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sie_valid = 0, sie_end = 0, sie_good = 0, cpu_rd = 0, cpu_wr = 0;
  logic [7:0] sie_data = 0, cpu_wdata = 0, cpu_rdata;
  logic [1:0] cpu_addr = 0;
  logic sie_ready;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_rx_pktbuf #(.DEPTH(DEPTH), .SCALED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sie_valid(sie_valid), .sie_data(sie_data),
    .sie_ready(sie_ready), .sie_end(sie_end), .sie_good(sie_good),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cpu_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(posedge clk); #1 cpu_wr = 0;
  endtask

  task automatic cpu_read(logic [1:0] a, output int d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    #1 d = cpu_rdata;
    @(posedge clk); #1 cpu_rd = 0;
  endtask

  task automatic send_pkt(int len, logic [7:0] seed, logic good);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); sie_valid = 1; sie_data = seed + 8'(i);
      @(posedge clk); #1 sie_valid = 0;
    end
    @(negedge clk); sie_end = 1; sie_good = good;
    @(posedge clk); #1 sie_end = 0;
  endtask

  task automatic read_count(output int c);
    int lo, hi;
    cpu_read(2'd1, lo);
    cpu_read(2'd2, hi);
    c = lo + 256 * hi;
  endtask

  task automatic drain(string tag, int len, logic [7:0] seed);
    int d, errs = 0, fa = 0, fe = 0;
    for (int i = 0; i < len; i++) begin
      cpu_read(2'd3, d);
      if (d != int'(8'(seed + 8'(i))) && errs == 0) begin fa = d; fe = int'(8'(seed + 8'(i))); end
      if (d != int'(8'(seed + 8'(i)))) errs++;
    end
    chk(tag, fa, fe);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, c, lim, expc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // reset state
    cpu_read(2'd0, v); chk("R1 reset size", v, 1);
    cpu_read(2'd1, v); chk("R7 reset low", v, 0);
    cpu_read(2'd2, v); chk("R7 reset high", v, 0);
    cpu_read(2'd3, v); chk("R9 empty data", v, 0);
    @(negedge clk); chk("R3 ready idle", int'(sie_ready), 1);
    cpu_write(2'd1, 8'hFF); cpu_write(2'd2, 8'hFF);
    read_count(c); chk("R7 write ignored", c, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [7:0] mx, sd; int ln; logic gd;
      mx = VEC[k][31:24]; ln = int'(VEC[k][23:12]); gd = VEC[k][11]; sd = VEC[k][7:0];
      lim = (mx * 8 > DEPTH) ? DEPTH : mx * 8;
      expc = (gd && ln > 0 && ln <= lim) ? ln : 0;
      cpu_write(2'd0, mx);
      cpu_read(2'd0, v); chk("R1 size readback", v, int'(mx));
      send_pkt(ln, sd, gd);
      read_count(c);
      chk($sformatf("R4 R5 R6 R10 R7 count vec %0d", k), c, expc);
      if (expc > 0) begin
        drain($sformatf("R4 data vec %0d", k), expc, sd);
        read_count(c); chk("R9 empty after drain", c, 0);
      end else begin
        cpu_read(2'd3, v); chk("R9 no data after discard", v, 0);
      end
    end

    // dual mode at exactly half the depth
    cpu_write(2'd0, 8'd16);
    send_pkt(10, 8'h80, 1);
    @(negedge clk); chk("R2 dual ready after one", int'(sie_ready), 1);
    send_pkt(20, 8'h90, 1);
    @(negedge clk); chk("R3 full not ready", int'(sie_ready), 0);
    send_pkt(5, 8'hA0, 1);
    read_count(c); chk("R9 oldest count", c, 10);
    drain("R4 dual first data", 10, 8'h80);
    read_count(c); chk("R9 next count", c, 20);
    @(negedge clk); chk("R3 ready after pop", int'(sie_ready), 1);
    drain("R4 dual second data", 20, 8'h90);
    read_count(c); chk("R3 dropped packet absent", c, 0);

    // single mode one step above half
    cpu_write(2'd0, 8'd17);
    send_pkt(5, 8'hB0, 1);
    @(negedge clk); chk("R2 single not ready", int'(sie_ready), 0);
    read_count(c); chk("R2 single count", c, 5);
    drain("R4 single data", 5, 8'hB0);
    @(negedge clk); chk("R2 single ready again", int'(sie_ready), 1);

    // shadow of high bits
    cpu_write(2'd0, 8'd32);
    cpu_read(2'd1, v); chk("R8 low when empty", v, 0);
    send_pkt(256, 8'hC0, 1);
    cpu_read(2'd2, v); chk("R8 high from shadow", v, 0);
    cpu_read(2'd1, v); chk("R7 low of 256", v, 0);
    cpu_read(2'd2, v); chk("R7 high of 256", v, 1);
    drain("R4 large data", 256, 8'hC0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule